// File: doc/BRIEF.md
# Multiplexed Bus RAM and Register Front End

This block sits between an 8-bit processor bus and the storage and control registers of a combined RAM, I/O port and timer device. The processor places an 8-bit address on a shared address/data bus. It frames that address with an address strobe, and along with it it presents a memory-or-I/O select and an active-high chip disable. The block captures all three when the strobe drops. Later read and write strobes then use the captured values.

Accesses with the memory select low go to a 256-byte RAM held inside the block. Accesses with it high go to one of six I/O slots, chosen by the three low address bits. The slots are command/status, port A, port B, port C, timer low and timer high. The port and timer logic sits outside this block and is reached through per-slot write strobes, a shared write-data bus and per-slot read-data inputs. The command register lives here. Writing slot 0 loads the command register, and reading slot 0 returns the externally supplied status word. The bus output enable is asserted only during a selected read.

Top module: `mux_bus_front`

## Requirements
- R1: While `ale_i` is high, each clock captures `ad_i`, `io_sel_i` and `cs_n_i`. Once `ale_i` is low, later changes on those inputs do not alter the target of the access.
- R2: When the captured `cs_n_i` is 1, no RAM location, command bit or slot strobe changes, and `ad_oe_o` and `status_rd_o` stay 0.
- R3: When the captured `io_sel_i` is 0, a write stores into RAM location `addr` and a read returns it. When it is 1, RAM is neither read nor written.
- R4: Only captured address bits [2:0] pick the I/O slot. Slots 1..5 are port A, port B, port C, timer low and timer high. A write to slot k raises bit k-1 of `reg_we_o`, at most one bit at a time. Reads return the matching `*_rdata_i`.
- R5: `ad_oe_o` is 1 exactly while `rd_ni` is 0, `wr_ni` is 1 and the device is selected. Otherwise it is 0 and `ad_o` is 0.
- R6: An I/O write to slot 0 loads `cmd_o`. An I/O read of slot 0 returns `status_i`, and `status_rd_o` pulses for one cycle, in the first cycle of `rd_ni` low.
- R7: While `rst_ni` is 0, `cmd_o` is 0 and the captured chip disable is 1, so the device is deselected.
- R8: I/O slots 6 and 7 read as 0x00. Writes to them raise no strobe and leave `cmd_o` unchanged.
- R9: `ad_oe_o` is never 1 while `wr_ni` is 0. When both strobes are low, the write takes effect and the bus is not driven.
- R10: Each high-to-low transition of `wr_ni` performs exactly one write, using the `ad_i` value of the first low cycle, however long `wr_ni` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ale_i | input | 1 | Address strobe; capture while high |
| ad_i | input | 8 | Address/data bus, input side |
| ad_o | output | 8 | Address/data bus, output side |
| ad_oe_o | output | 1 | Output enable for the bus |
| io_sel_i | input | 1 | 1 = I/O slots, 0 = RAM |
| cs_n_i | input | 1 | Chip disable, active high |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| cmd_o | output | 8 | Command register |
| status_i | input | 8 | Status word for slot 0 reads |
| status_rd_o | output | 1 | One-cycle pulse on a status read |
| wdata_o | output | 8 | Write data to slots 1..5 |
| reg_we_o | output | 5 | One-hot write strobe for slots 1..5 |
| pa_rdata_i | input | 8 | Port A read data |
| pb_rdata_i | input | 8 | Port B read data |
| pc_rdata_i | input | 8 | Port C read data |
| tlo_rdata_i | input | 8 | Timer low read data |
| thi_rdata_i | input | 8 | Timer high read data |

## Verification
The bench puts write data on the bus right after the address strobe falls, and in one case that data is itself a valid RAM address. A front end that kept capturing after the strobe would then write the wrong location, and the bench would read it back wrong. It uses I/O addresses whose upper bits are set to catch a decoder that looks at more than three bits. It holds a write strobe low for several cycles to catch a repeated write. It also overlaps the read and write strobes to catch a bus driven against an incoming write. A deselected write must leave the RAM and the command register unchanged. A status read must give exactly one pulse. Slots 6 and 7 must read zero and must not disturb the command register.

// File: rtl/mbf_pkg.sv
`timescale 1ns/1ps
package mbf_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int SLOT_W    = 3;
  localparam int NUM_WREGS = 5;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_CMD = 3'd0,
    SLOT_PA  = 3'd1,
    SLOT_PB  = 3'd2,
    SLOT_PC  = 3'd3,
    SLOT_TLO = 3'd4,
    SLOT_THI = 3'd5,
    SLOT_NA6 = 3'd6,
    SLOT_NA7 = 3'd7
  } slot_e;
endpackage

// File: rtl/mbf_addr_latch.sv
`timescale 1ns/1ps
module mbf_addr_latch #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ale_i,
  input  logic [ADDR_W-1:0] ad_i,
  input  logic              io_sel_i,
  input  logic              cs_n_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              io_o,
  output logic              sel_o
);
  logic cs_n_q;

  // follows the bus while the strobe is high, holds once it falls (R1)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      io_o   <= 1'b0;
      cs_n_q <= 1'b1;
    end else if (ale_i) begin
      addr_o <= ad_i;
      io_o   <= io_sel_i;
      cs_n_q <= cs_n_i;
    end
  end

  assign sel_o = ~cs_n_q;
endmodule

// File: rtl/mbf_strobe.sv
`timescale 1ns/1ps
module mbf_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic rd_ni,
  input  logic wr_ni,
  output logic wr_fire_o,
  output logic rd_start_o,
  output logic oe_o
);
  logic wr_nq, rd_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_nq <= 1'b1;
      rd_nq <= 1'b1;
    end else begin
      wr_nq <= wr_ni;
      rd_nq <= rd_ni;
    end
  end

  // one write per strobe, taken in its first low cycle (R10)
  assign wr_fire_o  = sel_i & ~wr_ni & wr_nq;
  // write wins over read: no drive while wr is low (R9)
  assign oe_o       = sel_i & ~rd_ni & wr_ni;
  assign rd_start_o = oe_o & rd_nq;
endmodule

// File: rtl/mbf_ram.sv
`timescale 1ns/1ps
module mbf_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/mbf_io_regs.sv
`timescale 1ns/1ps
module mbf_io_regs
  import mbf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int SW    = 3,
  parameter int NWREG = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             rd_start_i,
  input  logic [SW-1:0]    slot_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    status_i,
  input  logic [DW-1:0]    slot_rdata_i [NWREG],
  output logic [DW-1:0]    cmd_o,
  output logic [NWREG-1:0] reg_we_o,
  output logic             status_rd_o,
  output logic [DW-1:0]    rdata_o
);
  logic is_cmd;
  assign is_cmd = (slot_i == SW'(SLOT_CMD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cmd_o <= '0;
    else if (we_i && is_cmd) cmd_o <= wdata_i;
  end

  for (genvar g = 0; g < NWREG; g++) begin : g_we
    assign reg_we_o[g] = we_i && (slot_i == SW'(g + 1));
  end

  assign status_rd_o = rd_start_i && is_cmd;

  always_comb begin
    rdata_o = '0;
    if (is_cmd) begin
      rdata_o = status_i;
    end else begin
      for (int k = 0; k < NWREG; k++) begin
        if (slot_i == SW'(k + 1)) rdata_o = slot_rdata_i[k];
      end
    end
  end
endmodule

// File: rtl/mux_bus_front.sv
`timescale 1ns/1ps
module mux_bus_front
  import mbf_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ale_i,
  input  logic [DATA_W-1:0]    ad_i,
  output logic [DATA_W-1:0]    ad_o,
  output logic                 ad_oe_o,
  input  logic                 io_sel_i,
  input  logic                 cs_n_i,
  input  logic                 rd_ni,
  input  logic                 wr_ni,
  output logic [DATA_W-1:0]    cmd_o,
  input  logic [DATA_W-1:0]    status_i,
  output logic                 status_rd_o,
  output logic [DATA_W-1:0]    wdata_o,
  output logic [NUM_WREGS-1:0] reg_we_o,
  input  logic [DATA_W-1:0]    pa_rdata_i,
  input  logic [DATA_W-1:0]    pb_rdata_i,
  input  logic [DATA_W-1:0]    pc_rdata_i,
  input  logic [DATA_W-1:0]    tlo_rdata_i,
  input  logic [DATA_W-1:0]    thi_rdata_i
);
  logic [ADDR_W-1:0] addr_lat;
  logic              io_lat, sel_lat;
  logic              wr_fire, rd_start, oe;
  logic [DATA_W-1:0] ram_rdata, io_rdata;
  logic [DATA_W-1:0] slot_rdata [NUM_WREGS];

  assign slot_rdata[0] = pa_rdata_i;
  assign slot_rdata[1] = pb_rdata_i;
  assign slot_rdata[2] = pc_rdata_i;
  assign slot_rdata[3] = tlo_rdata_i;
  assign slot_rdata[4] = thi_rdata_i;

  mbf_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk_i, .rst_ni, .ale_i, .ad_i(ad_i[ADDR_W-1:0]), .io_sel_i, .cs_n_i,
    .addr_o(addr_lat), .io_o(io_lat), .sel_o(sel_lat)
  );

  mbf_strobe u_strobe (
    .clk_i, .rst_ni, .sel_i(sel_lat), .rd_ni, .wr_ni,
    .wr_fire_o(wr_fire), .rd_start_o(rd_start), .oe_o(oe)
  );

  mbf_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk_i, .we_i(wr_fire & ~io_lat), .addr_i(addr_lat),
    .wdata_i(ad_i), .rdata_o(ram_rdata)
  );

  mbf_io_regs #(.DW(DATA_W), .SW(SLOT_W), .NWREG(NUM_WREGS)) u_regs (
    .clk_i, .rst_ni,
    .we_i(wr_fire & io_lat), .rd_start_i(rd_start & io_lat),
    .slot_i(addr_lat[SLOT_W-1:0]), .wdata_i(ad_i), .status_i,
    .slot_rdata_i(slot_rdata), .cmd_o, .reg_we_o, .status_rd_o,
    .rdata_o(io_rdata)
  );

  assign wdata_o = ad_i;
  assign ad_oe_o = oe;
  assign ad_o    = oe ? (io_lat ? io_rdata : ram_rdata) : '0;
endmodule

// File: rtl/mbf_chk.sv
`timescale 1ns/1ps
module mbf_chk #(
  parameter int NW = 5,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_ni,
  input logic          wr_ni,
  input logic          ad_oe_o,
  input logic [NW-1:0] reg_we_o,
  input logic [DW-1:0] cmd_o,
  input logic          status_rd_o,
  input logic          sel_i
);
  // R9
  oe_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> wr_ni);
  // R5
  oe_needs_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> (!rd_ni && sel_i));
  // R2
  desel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> (!ad_oe_o && reg_we_o == '0 && !status_rd_o));
  // R4
  we_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reg_we_o));
  // R10
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o != '0) |=> (reg_we_o == '0));
  // R6
  cmd_only_on_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmd_o) |-> $past(!wr_ni));
  // R6
  status_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rd_o |-> (ad_oe_o && $fell(rd_ni)));
endmodule

bind mux_bus_front mbf_chk #(.NW(mbf_pkg::NUM_WREGS), .DW(mbf_pkg::DATA_W)) u_mbf_chk (
  .clk_i, .rst_ni, .rd_ni, .wr_ni, .ad_oe_o, .reg_we_o, .cmd_o, .status_rd_o,
  .sel_i(sel_lat)
);

// File: tb/test_mux_bus_front.sv
`timescale 1ns/1ps
module test_mux_bus_front;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ale = 1'b0, io = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] ad = 8'h00;
  logic [7:0] ad_o, cmd_o, wdata_o;
  logic       ad_oe_o, status_rd_o;
  logic [4:0] reg_we_o;
  localparam logic [7:0] ST = 8'h5A, PA = 8'h11, PB = 8'h22, PC = 8'h33,
                         TL = 8'h44, TH = 8'h55;

  always #10 clk = ~clk;

  mux_bus_front i_mux_bus_front (
    .clk_i(clk), .rst_ni(rst_n), .ale_i(ale), .ad_i(ad), .ad_o, .ad_oe_o,
    .io_sel_i(io), .cs_n_i(cs_n), .rd_ni(rd_n), .wr_ni(wr_n), .cmd_o,
    .status_i(ST), .status_rd_o, .wdata_o, .reg_we_o,
    .pa_rdata_i(PA), .pb_rdata_i(PB), .pc_rdata_i(PC),
    .tlo_rdata_i(TL), .thi_rdata_i(TH)
  );

  int errors = 0, checks = 0;
  bit done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int ram_m [256];
  int cmd_m = 0, addr_m = 0;
  bit io_m = 0, cs_m = 1, wr_p = 1, rd_p = 1;
  initial foreach (ram_m[i]) ram_m[i] = -1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_m = 0; addr_m = 0; io_m = 0; cs_m = 1; wr_p = 1; rd_p = 1;
    end else begin
      if (!wr_n && wr_p && !cs_m) begin
        if (io_m) begin
          if (addr_m % 8 == 0) cmd_m = ad;
        end else ram_m[addr_m] = ad;
      end
      if (ale) begin addr_m = ad; io_m = io; cs_m = cs_n; end
      wr_p = wr_n; rd_p = rd_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int idx, exp_we, exp_d;
      bit exp_oe, exp_srd;
      idx     = addr_m % 8;
      exp_oe  = !rd_n && !cs_m && wr_n;
      exp_srd = exp_oe && rd_p && io_m && idx == 0;
      exp_we  = 0;
      if (!wr_n && wr_p && !cs_m && io_m && idx >= 1 && idx <= 5) exp_we = 1 << (idx - 1);
      check("R5 oe", ad_oe_o, exp_oe);
      check("R4 reg_we", reg_we_o, exp_we);
      check("R6 cmd", cmd_o, cmd_m);
      check("R6 status_rd", status_rd_o, exp_srd);
      if (exp_oe) begin
        if (io_m) begin
          case (idx)
            0: exp_d = ST; 1: exp_d = PA; 2: exp_d = PB; 3: exp_d = PC;
            4: exp_d = TL; 5: exp_d = TH; default: exp_d = 0;
          endcase
        end else exp_d = ram_m[addr_m];
        if (exp_d >= 0) check("R3 read data", ad_o, exp_d);
      end else check("R5 idle bus", ad_o, 0);
    end
  end

  task automatic step();
    @(posedge clk); #5;
  endtask

  logic [7:0] rd_val;
  int oe_cnt, we_cnt, srd_cnt;
  logic [4:0] we_or;

  task automatic bus(input bit io_v, input bit csn_v, input logic [7:0] addr,
                     input bit do_wr, input bit do_rd, input logic [7:0] wd,
                     input int hold);
    oe_cnt = 0; we_cnt = 0; srd_cnt = 0; we_or = '0; rd_val = 8'hxx;
    step(); ale = 1; ad = addr; io = io_v; cs_n = csn_v;
    step(); ale = 0; ad = do_wr ? wd : 8'hEE; io = ~io_v; cs_n = ~csn_v;
    step(); wr_n = !do_wr; rd_n = !do_rd;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (i == 0) rd_val = ad_o;
      oe_cnt += ad_oe_o; we_cnt += (reg_we_o != 0); srd_cnt += status_rd_o;
      we_or |= reg_we_o;
      if (i < hold - 1) step();
    end
    step(); wr_n = 1; rd_n = 1;
    @(negedge clk);
    we_cnt += (reg_we_o != 0); srd_cnt += status_rd_o;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R7 cmd in reset", cmd_o, 0);
    check("R7 oe in reset", ad_oe_o, 0);
    rst_n = 1;
    step();
    // R3 ram write/read
    bus(0, 0, 8'h9C, 1, 0, 8'h01, 1);
    bus(0, 0, 8'h40, 1, 0, 8'h9C, 1);  // R1: data is itself an address
    bus(0, 0, 8'h9C, 0, 1, 8'h00, 2);
    check("R1 untouched 0x9C", rd_val, 8'h01);
    bus(0, 0, 8'h40, 0, 1, 8'h00, 2);
    check("R1 target 0x40", rd_val, 8'h9C);
    check("R5 read drives", oe_cnt, 2);
    // R2 deselected
    bus(0, 1, 8'h40, 1, 0, 8'h77, 1);
    bus(1, 1, 8'h00, 1, 0, 8'hFF, 1);
    check("R2 cmd unchanged", cmd_o, 0);
    bus(0, 1, 8'h40, 0, 1, 8'h00, 2);
    check("R2 no drive", oe_cnt, 0);
    bus(0, 0, 8'h40, 0, 1, 8'h00, 1);
    check("R2 ram kept", rd_val, 8'h9C);
    // R3 io vs ram
    bus(0, 0, 8'h41, 1, 0, 8'h05, 1);
    bus(1, 0, 8'h41, 1, 0, 8'hA0, 1);
    check("R3 io write strobe A", we_or, 5'b00001);
    bus(0, 0, 8'h41, 0, 1, 8'h00, 1);
    check("R3 ram not hit by io", rd_val, 8'h05);
    // R4 decode
    bus(1, 0, 8'hFB, 1, 0, 8'h3C, 1);
    check("R4 port C strobe", we_or, 5'b00100);
    bus(1, 0, 8'hFC, 0, 1, 8'h00, 1);
    check("R4 timer low read", rd_val, TL);
    bus(1, 0, 8'h0D, 0, 1, 8'h00, 1);
    check("R4 timer high read", rd_val, TH);
    bus(1, 0, 8'h0A, 0, 1, 8'h00, 1);
    check("R4 port B read", rd_val, PB);
    // R6 command / status
    bus(1, 0, 8'h00, 1, 0, 8'hC3, 1);
    check("R6 cmd load", cmd_o, 8'hC3);
    bus(1, 0, 8'hF8, 0, 1, 8'h00, 3);
    check("R6 status read", rd_val, ST);
    check("R6 status pulse count", srd_cnt, 1);
    // R8 unused slots
    bus(1, 0, 8'h06, 1, 0, 8'h99, 1);
    check("R8 no strobe", we_or, 0);
    check("R8 cmd kept", cmd_o, 8'hC3);
    bus(1, 0, 8'h07, 0, 1, 8'h00, 1);
    check("R8 read zero", rd_val, 0);
    // R9 overlap
    bus(1, 0, 8'h02, 1, 1, 8'h6B, 2);
    check("R9 no drive", oe_cnt, 0);
    check("R9 write happens", we_or, 5'b00010);
    // R10 long strobe
    bus(1, 0, 8'h05, 1, 0, 8'h12, 4);
    check("R10 one write", we_cnt, 1);
    // R7 reset mid-run
    step(); rst_n = 0;
    @(negedge clk);
    check("R7 cmd cleared", cmd_o, 0);
    step(); rst_n = 1;
    bus(0, 0, 8'h40, 0, 1, 8'h00, 1);  // latch reset then rewritten
    step();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule